// File: doc/BRIEF.md
# SD Host Single-Operation DMA Boundary Engine

This block is the single-operation DMA path of an SD host controller. Software programs a start address, a block geometry (block length in bytes plus a buffer boundary selector) and a block count, then writes the mode register with its go bit. The engine then moves 32-bit words between a ready/valid card-side word stream and a simple memory port, one word per handshake. The address advances by four bytes per word.

Whenever the advanced address lands on a multiple of the selected boundary and words still remain, the engine raises a boundary status bit and holds the stream. It continues only when software writes the address register again, from the address written. After the last word of the last block it raises a transfer-done status bit. Both status bits are cleared by writing one to them, and their OR drives a single interrupt line.

Register select codes: 0 address, 1 geometry, 2 block count, 3 mode, 4 status.

Top module: `sd_blkdma_engine`

## Requirements
- R1: After reset every register reads zero, the interrupt line is low, and neither memory strobe nor the card-side ready or valid is asserted.
- R2: With mode bit 4 set (card to memory), each word accepted on the input stream is written to memory at the current address. The address register then reads four more.
- R3: With mode bit 4 clear (memory to card), words are read from memory at ascending addresses and presented in that order on the output stream. A memory read returns data one cycle after the read strobe.
- R4: The boundary size is 4 KiB shifted left by geometry bits [14:12]. When the address after a word is a multiple of it and words remain, status bit 3 is set and the stream stops: no ready, no memory access.
- R5: Status bit 1 is set after the last word of the last block. A boundary hit on that final word does not set status bit 3.
- R6: Writing the address register while paused resumes the transfer from the written address.
- R7: With mode bit 1 set, the block count register decrements once per completed block. With it clear, the register keeps its value.
- R8: Starting with a block count of zero sets status bit 1 at once and makes no memory access.
- R9: Writing the status register clears each bit written as one and leaves bits written as zero. The interrupt line is high while either status bit is set.
- R10: Writes to geometry, block count and mode are ignored while a transfer is running or paused.
- R11: A mode write with bit 0 set while idle starts a transfer. The block length in words is geometry bits [11:0] divided by four, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data, valid one cycle after memRdEn |
| cardInValid | input | 1 | Card-to-memory word valid |
| cardInData | input | 32 | Card-to-memory word |
| cardInReady | output | 1 | Engine accepts a card word |
| cardOutValid | output | 1 | Memory-to-card word valid |
| cardOutData | output | 32 | Memory-to-card word |
| cardOutReady | input | 1 | Card side accepts the word |
| irq | output | 1 | OR of the status bits |

## Verification
A wrong word counter or block counter shows up right after the transfer. The done bit comes too early or too late, the address register reads a different final value, or the count register is off by one block. A wrong boundary mask shows within one word of the crossing: the engine pauses at an address that is not a multiple of the boundary, or it runs straight past one. Broken pause or resume logic shows at once on the stream. Ready stays high while paused, or the words after the resume land at the old address instead of the written one.

// File: rtl/sd_dma_pkg.sv
package sdDmaPkg;
  // register select codes
  localparam logic [2:0] SEL_SYSADDR = 3'd0;
  localparam logic [2:0] SEL_GEOM    = 3'd1;
  localparam logic [2:0] SEL_COUNT   = 3'd2;
  localparam logic [2:0] SEL_MODE    = 3'd3;
  localparam logic [2:0] SEL_STATUS  = 3'd4;

  // mode register bits
  localparam int MODE_GO_BIT    = 0;
  localparam int MODE_CNTEN_BIT = 1;
  localparam int MODE_DIR_BIT   = 4;

  // status register bits
  localparam int STAT_DONE_BIT  = 1;
  localparam int STAT_PAUSE_BIT = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic start;     // load block and word counters
    logic wordStep;  // one word moved
    logic capture;   // latch memory read data
    logic pauseSet;  // raise boundary status
    logic doneSet;   // raise done status
    logic regsOpen;  // geometry/count/mode writable
    logic addrOpen;  // address register writable
  } dpCtrlT;
endpackage

// File: rtl/sd_dma_datapath.sv
module sd_dma_datapath
  import sdDmaPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SIZE_W    = 12,
  parameter int BOUND_W   = 3,
  parameter int BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctrl,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [31:0]       rdBuf,
  output logic              lastWord,
  output logic              lastBlock,
  output logic              boundaryHit,
  output logic              countZero,
  output logic              dirToMem,
  output logic              irq
);
  localparam int WCNT_W     = SIZE_W - 2;
  localparam int WORD_BYTES = 4;

  logic [ADDR_W-1:0]  sysAddr;
  logic [SIZE_W-1:0]  geomSize;
  logic [BOUND_W-1:0] boundSel;
  logic [CNT_W-1:0]   countReg;
  logic [CNT_W-1:0]   blocksLeft;
  logic [WCNT_W-1:0]  wordCnt;
  logic [WCNT_W-1:0]  wordsPerBlock;
  logic               countEn;
  logic               statDone;
  logic               statPause;
  logic [ADDR_W-1:0]  nextAddr;
  logic [ADDR_W-1:0]  boundMask;

  logic wrSys, wrGeom, wrCount, wrMode, wrStatus;
  assign wrSys    = regWrEn && (regSel == SEL_SYSADDR);
  assign wrGeom   = regWrEn && (regSel == SEL_GEOM);
  assign wrCount  = regWrEn && (regSel == SEL_COUNT);
  assign wrMode   = regWrEn && (regSel == SEL_MODE);
  assign wrStatus = regWrEn && (regSel == SEL_STATUS);

  assign wordsPerBlock = (geomSize[SIZE_W-1:2] == '0) ? WCNT_W'(1) : geomSize[SIZE_W-1:2];
  assign nextAddr      = sysAddr + ADDR_W'(WORD_BYTES);
  assign boundMask     = (ADDR_W'(1) << (ADDR_W'(BASE_LOG2) + ADDR_W'(boundSel))) - ADDR_W'(1);
  assign boundaryHit   = ((nextAddr & boundMask) == '0);
  assign lastWord      = (wordCnt == WCNT_W'(1));
  assign lastBlock     = (blocksLeft == CNT_W'(1));
  assign countZero     = (countReg == '0);
  assign curAddr       = sysAddr;
  assign irq           = statDone | statPause;

  // address register: software load when open, engine advance otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysAddr <= '0;
    else if (wrSys && ctrl.addrOpen) sysAddr <= regWrData[ADDR_W-1:0];
    else if (ctrl.wordStep) sysAddr <= nextAddr;
  end

  // geometry and mode, writable only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      geomSize <= '0;
      boundSel <= '0;
      countEn  <= 1'b0;
      dirToMem <= 1'b0;
    end else if (ctrl.regsOpen) begin
      if (wrGeom) begin
        geomSize <= regWrData[SIZE_W-1:0];
        boundSel <= regWrData[SIZE_W +: BOUND_W];
      end
      if (wrMode) begin
        countEn  <= regWrData[MODE_CNTEN_BIT];
        dirToMem <= regWrData[MODE_DIR_BIT];
      end
    end
  end

  // software-visible block count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countReg <= '0;
    else if (wrCount && ctrl.regsOpen) countReg <= regWrData[CNT_W-1:0];
    else if (ctrl.wordStep && lastWord && countEn) countReg <= countReg - CNT_W'(1);
  end

  // internal progress counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blocksLeft <= '0;
      wordCnt    <= '0;
    end else if (ctrl.start) begin
      blocksLeft <= countReg;
      wordCnt    <= wordsPerBlock;
    end else if (ctrl.wordStep) begin
      if (lastWord) begin
        blocksLeft <= blocksLeft - CNT_W'(1);
        wordCnt    <= wordsPerBlock;
      end else begin
        wordCnt <= wordCnt - WCNT_W'(1);
      end
    end
  end

  // read holding buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdBuf <= '0;
    else if (ctrl.capture) rdBuf <= memRdData;
  end

  // status bits: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statDone  <= 1'b0;
      statPause <= 1'b0;
    end else begin
      if (ctrl.doneSet) statDone <= 1'b1;
      else if (wrStatus && regWrData[STAT_DONE_BIT]) statDone <= 1'b0;
      if (ctrl.pauseSet) statPause <= 1'b1;
      else if (wrStatus && regWrData[STAT_PAUSE_BIT]) statPause <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_SYSADDR: regRdData = 32'(sysAddr);
      SEL_GEOM:    regRdData = 32'({boundSel, geomSize});
      SEL_COUNT:   regRdData = 32'(countReg);
      SEL_MODE: begin
        regRdData[MODE_CNTEN_BIT] = countEn;
        regRdData[MODE_DIR_BIT]   = dirToMem;
      end
      SEL_STATUS: begin
        regRdData[STAT_DONE_BIT]  = statDone;
        regRdData[STAT_PAUSE_BIT] = statPause;
      end
      default: regRdData = '0;
    endcase
  end

  // a pause always leaves the address on a boundary multiple
  assert_pause_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statPause) |-> ((sysAddr & boundMask) == '0));

  // done only once every block has been consumed
  assert_done_drained_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDone) |-> (blocksLeft == '0));

  // geometry frozen while a transfer owns it
  assert_geom_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.regsOpen |=> ($stable(geomSize) && $stable(boundSel)));
endmodule

// File: rtl/sd_dma_control.sv
module sd_dma_control
  import sdDmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regSel,
  input  logic [31:0] regWrData,
  input  logic        lastWord,
  input  logic        lastBlock,
  input  logic        boundaryHit,
  input  logic        countZero,
  input  logic        dirToMem,
  input  logic        cardInValid,
  output logic        cardInReady,
  output logic        cardOutValid,
  input  logic        cardOutReady,
  output logic        memWrEn,
  output logic        memRdEn,
  output dpCtrlT      ctrl
);
  typedef enum logic [2:0] {S_IDLE, S_RECV, S_FETCH, S_LOAD, S_SEND, S_PAUSE} stateT;
  stateT state, stateNext;

  logic startReq, resumeReq, moved;
  stateT runState;

  assign startReq  = regWrEn && (regSel == SEL_MODE) && regWrData[MODE_GO_BIT] && (state == S_IDLE);
  assign resumeReq = regWrEn && (regSel == SEL_SYSADDR) && (state == S_PAUSE);
  assign runState  = dirToMem ? S_RECV : S_FETCH;

  assign cardInReady  = (state == S_RECV);
  assign cardOutValid = (state == S_SEND);
  assign memRdEn      = (state == S_FETCH);
  assign memWrEn      = cardInReady && cardInValid;
  assign moved        = memWrEn || (cardOutValid && cardOutReady);

  always_comb begin
    stateNext     = state;
    ctrl          = '0;
    ctrl.regsOpen = (state == S_IDLE);
    ctrl.addrOpen = (state == S_IDLE) || (state == S_PAUSE);
    ctrl.wordStep = moved;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          ctrl.start = 1'b1;
          if (countZero) ctrl.doneSet = 1'b1;
          else stateNext = regWrData[MODE_DIR_BIT] ? S_RECV : S_FETCH;
        end
      end
      S_FETCH: stateNext = S_LOAD;
      S_LOAD: begin
        ctrl.capture = 1'b1;
        stateNext    = S_SEND;
      end
      S_RECV, S_SEND: begin
        if (moved) begin
          if (lastWord && lastBlock) begin
            ctrl.doneSet = 1'b1;
            stateNext    = S_IDLE;
          end else if (boundaryHit) begin
            ctrl.pauseSet = 1'b1;
            stateNext     = S_PAUSE;
          end else begin
            stateNext = runState;
          end
        end
      end
      S_PAUSE: if (resumeReq) stateNext = runState;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= stateNext;
  end

  // no traffic of any kind while held at a boundary
  assert_quiet_paused_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAUSE) |-> (!memWrEn && !memRdEn && !cardInReady && !cardOutValid));

  // at most one memory strobe per cycle
  assert_mem_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

  // a boundary pause is only entered from a moving word
  assert_pause_from_move_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pauseSet |-> moved);
endmodule

// File: rtl/sd_blkdma_engine.sv
module sd_blkdma_engine
  import sdDmaPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SIZE_W    = 12,
  parameter int BOUND_W   = 3,
  parameter int BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  input  logic [31:0]       memRdData,
  input  logic              cardInValid,
  input  logic [31:0]       cardInData,
  output logic              cardInReady,
  output logic              cardOutValid,
  output logic [31:0]       cardOutData,
  input  logic              cardOutReady,
  output logic              irq
);
  dpCtrlT ctrl;
  logic lastWord, lastBlock, boundaryHit, countZero, dirToMem;

  assign memWrData = cardInData;

  sd_dma_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .lastWord(lastWord), .lastBlock(lastBlock), .boundaryHit(boundaryHit),
    .countZero(countZero), .dirToMem(dirToMem),
    .cardInValid(cardInValid), .cardInReady(cardInReady),
    .cardOutValid(cardOutValid), .cardOutReady(cardOutReady),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .ctrl(ctrl)
  );

  sd_dma_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W),
    .BOUND_W(BOUND_W), .BASE_LOG2(BASE_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .memRdData(memRdData), .curAddr(memAddr), .rdBuf(cardOutData),
    .lastWord(lastWord), .lastBlock(lastBlock), .boundaryHit(boundaryHit),
    .countZero(countZero), .dirToMem(dirToMem), .irq(irq)
  );
endmodule

// File: tb/sd_blkdma_engine_tb.sv
module sd_blkdma_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memWrEn, memRdEn;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;
  logic        cardInValid = 1'b0;
  logic [31:0] cardInData = '0;
  logic        cardInReady;
  logic        cardOutValid;
  logic [31:0] cardOutData;
  logic        cardOutReady = 1'b1;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int wrEvents = 0;
  int rdEvents = 0;
  logic [31:0] mem [0:4095];

  always #10 clk = ~clk;

  sd_blkdma_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData),
    .cardInValid(cardInValid), .cardInData(cardInData), .cardInReady(cardInReady),
    .cardOutValid(cardOutValid), .cardOutData(cardOutData), .cardOutReady(cardOutReady),
    .irq(irq)
  );

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr[13:2]] <= memWrData;
      wrEvents <= wrEvents + 1;
    end
    if (memRdEn) begin
      memRdData <= mem[memAddr[13:2]];
      rdEvents <= rdEvents + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = regRdData;
  endtask

  task automatic startXfer(input logic [31:0] addr, input logic [31:0] geom,
                           input logic [31:0] cnt, input logic [31:0] mode);
    writeReg(3'd0, addr);
    writeReg(3'd1, geom);
    writeReg(3'd2, cnt);
    writeReg(3'd3, mode);
  endtask

  task automatic pushWords(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      int waitCnt = 0;
      @(negedge clk);
      cardInValid = 1'b1;
      cardInData = base + 32'(i);
      #1;
      while (!cardInReady && waitCnt < 200) begin
        @(negedge clk); #1; waitCnt++;
      end
      if (!cardInReady) check(1'b0, "R2 stream stuck", 32'(i), 32'(n));
      @(posedge clk);
    end
    @(negedge clk);
    cardInValid = 1'b0;
  endtask

  task automatic popWords(input int n, input logic [31:0] addr, input string req);
    for (int i = 0; i < n; i++) begin
      int waitCnt = 0;
      @(negedge clk); #1;
      while (!cardOutValid && waitCnt < 200) begin
        @(negedge clk); #1; waitCnt++;
      end
      checkEq(req, cardOutData, mem[(addr >> 2) + 32'(i)]);
      @(posedge clk);
    end
  endtask

  task automatic clearStatus();
    writeReg(3'd4, 32'h0000_000A);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int s = 0; s < 5; s++) begin
      readReg(3'(s), v);
      checkEq("R1 register reset", v, 32'h0);
    end
    checkEq("R1 irq reset", 32'(irq), 32'h0);
    checkEq("R1 strobes idle", {28'h0, memWrEn, memRdEn, cardInReady, cardOutValid}, 32'h0);
  endtask

  task automatic testWriteBasic();
    logic [31:0] v;
    clearStatus();
    startXfer(32'h100, 32'h0010, 32'd3, 32'h13);
    pushWords(12, 32'hC000_0000);
    readReg(3'd4, v); checkEq("R5 done after last block", v, 32'h2);
    readReg(3'd0, v); checkEq("R2 address advance", v, 32'h130);
    readReg(3'd2, v); checkEq("R7 count decremented", v, 32'h0);
    checkEq("R2 first word", mem[32'h100 >> 2], 32'hC000_0000);
    checkEq("R2 last word", mem[(32'h100 >> 2) + 11], 32'hC000_000B);
    checkEq("R11 words per block", mem[(32'h100 >> 2) + 4], 32'hC000_0004);
  endtask

  task automatic testCountHold();
    logic [31:0] v;
    clearStatus();
    startXfer(32'h400, 32'h0010, 32'd3, 32'h11);
    pushWords(12, 32'hD000_0000);
    readReg(3'd4, v); checkEq("R5 done count-hold run", v, 32'h2);
    readReg(3'd2, v); checkEq("R7 count held", v, 32'd3);
  endtask

  task automatic testPauseResume();
    logic [31:0] v;
    clearStatus();
    startXfer(32'h0FF0, 32'h0020, 32'd2, 32'h13);
    pushWords(4, 32'hA000_0000);
    readReg(3'd4, v); checkEq("R4 pause status", v, 32'h8);
    readReg(3'd0, v); checkEq("R4 pause address", v, 32'h1000);
    readReg(3'd2, v); checkEq("R7 count mid block", v, 32'd2);
    checkEq("R9 irq on pause", 32'(irq), 32'h1);
    @(negedge clk);
    cardInValid = 1'b1; cardInData = 32'hA000_0004;
    for (int k = 0; k < 3; k++) begin
      #1 checkEq("R4 stream held", {31'h0, cardInReady | memWrEn}, 32'h0);
      @(negedge clk);
    end
    cardInValid = 1'b0;
    writeReg(3'd1, 32'h0040);
    readReg(3'd1, v); checkEq("R10 geometry ignored", v, 32'h0020);
    writeReg(3'd2, 32'd9);
    readReg(3'd2, v); checkEq("R10 count ignored", v, 32'd2);
    writeReg(3'd4, 32'h8);
    readReg(3'd4, v); checkEq("R9 pause cleared", v, 32'h0);
    checkEq("R9 irq low", 32'(irq), 32'h0);
    writeReg(3'd0, 32'h2000);
    pushWords(12, 32'hA000_0004);
    readReg(3'd4, v); checkEq("R6 done after resume", v, 32'h2);
    readReg(3'd0, v); checkEq("R6 final address", v, 32'h2030);
    readReg(3'd2, v); checkEq("R7 count after resume", v, 32'd0);
    checkEq("R2 word before boundary", mem[(32'h0FF0 >> 2) + 3], 32'hA000_0003);
    checkEq("R6 first resumed word", mem[32'h2000 >> 2], 32'hA000_0004);
    checkEq("R6 last resumed word", mem[(32'h2000 >> 2) + 11], 32'hA000_000F);
  endtask

  task automatic testEndOnBoundary();
    logic [31:0] v;
    clearStatus();
    startXfer(32'h0FE0, 32'h0020, 32'd1, 32'h13);
    pushWords(8, 32'hB000_0000);
    readReg(3'd4, v); checkEq("R5 end on boundary no pause", v, 32'h2);
    readReg(3'd0, v); checkEq("R5 end address", v, 32'h1000);
  endtask

  task automatic testWideBoundary();
    logic [31:0] v;
    clearStatus();
    startXfer(32'h0FF8, 32'h1010, 32'd2, 32'h13);
    pushWords(8, 32'hE000_0000);
    readReg(3'd4, v); checkEq("R4 8K select skips 4K", v, 32'h2);
    clearStatus();
    startXfer(32'h1FF8, 32'h1010, 32'd1, 32'h13);
    pushWords(2, 32'hE100_0000);
    readReg(3'd4, v); checkEq("R4 8K pause", v, 32'h8);
    readReg(3'd0, v); checkEq("R4 8K pause address", v, 32'h2000);
    writeReg(3'd0, 32'h3000);
    pushWords(2, 32'hE100_0002);
    readReg(3'd4, v); checkEq("R6 8K resume done", v, 32'hA);
    checkEq("R6 8K resumed word", mem[(32'h3000 >> 2) + 1], 32'hE100_0003);
  endtask

  task automatic testReadDir();
    logic [31:0] v;
    clearStatus();
    for (int i = 0; i < 4; i++) mem[(32'h300 >> 2) + i] = 32'h5000_0000 + 32'(i * 7);
    startXfer(32'h300, 32'h0008, 32'd2, 32'h03);
    popWords(4, 32'h300, "R3 read data order");
    readReg(3'd4, v); checkEq("R5 read done", v, 32'h2);
    readReg(3'd0, v); checkEq("R3 read address", v, 32'h310);
  endtask

  task automatic testZeroCount();
    logic [31:0] v;
    int wBefore, rBefore;
    clearStatus();
    writeReg(3'd0, 32'h500);
    writeReg(3'd2, 32'd0);
    wBefore = wrEvents; rBefore = rdEvents;
    writeReg(3'd3, 32'h13);
    readReg(3'd4, v); checkEq("R8 zero count done", v, 32'h2);
    repeat (4) @(negedge clk);
    checkEq("R8 no memory traffic", 32'((wrEvents - wBefore) + (rdEvents - rBefore)), 32'h0);
    readReg(3'd0, v); checkEq("R8 address unchanged", v, 32'h500);
    writeReg(3'd4, 32'h8);
    readReg(3'd4, v); checkEq("R9 zero-written bit kept", v, 32'h2);
    checkEq("R9 irq while done", 32'(irq), 32'h1);
    writeReg(3'd4, 32'h2);
    readReg(3'd4, v); checkEq("R9 done cleared", v, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteBasic();
    testCountHold();
    testPauseResume();
    testEndOnBoundary();
    testWideBoundary();
    testReadDir();
    testZeroCount();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule